// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Data Memory

This block is the data-side storage of a 32-bit load/store core. Each address names a single byte. A load or store moves a byte, a half-word or a full word through one synchronous port. Within each stored word the byte at the lowest address is the most significant one. Stores of a byte or a half-word change only the byte lanes they address. Loads of a byte or a half-word place the selected bits at the low end of the 32-bit result and fill the upper bits with either the sign bit or zeros.

Every access is checked against its alignment rule as soon as it is presented. An access that breaks the rule raises a flag in the same cycle, leaves the storage untouched and returns zero read data. The storage depth is a parameter. Address bits above that depth are not decoded, so the array repeats across the 32-bit address space.

Top module: `be_data_mem`

## Requirements
- R1: The word at byte address 4N holds its most significant byte at 4N and its least significant byte at 4N+3. A byte load at 4N+k returns bits (31-8k):(24-8k) of the stored word, and a word load at 4N returns the stored word unchanged.
- R2: The size encoding is 2'b00 byte, 2'b01 half-word, 2'b10 word. A word access needs addr[1:0]==0 and a half-word access needs addr[0]==0, while a byte access is always aligned. Code 2'b11 is always rejected. `misalign` is high in the same cycle as any access that breaks these rules.
- R3: A store with `misalign` high leaves every byte of memory unchanged.
- R4: A byte store writes wdata[7:0] into the addressed lane only. A half-word store writes wdata[15:0] into bits 31:16 of the word at offset 0, or into bits 15:0 at offset 2. The other bytes of the word keep their values.
- R5: A byte or half-word load returns the selected bits right-justified in `rdata`. The upper bits copy the selected field's top bit when `sign_ext` is 1 and are zero when `sign_ext` is 0.
- R6: A store takes effect at the rising edge where it is presented. `rdata` shows the result for the access presented at the previous rising edge. An access that writes a word reads back that word's contents from before the write.
- R7: In the cycle after a rejected access, `rdata` is zero.
- R8: Address bits [31:IDX_W+2] are ignored, where IDX_W = log2(DEPTH). Two addresses that differ only in those bits reach the same byte.
- R9: While `rst_n` is low at a rising edge, the read result is cleared, so `rdata` is zero after reset. Memory contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 32 | Byte address of the access |
| size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| wr_en | input | 1 | High for a store, low for a load |
| wdata | input | 32 | Store data, right-justified for narrow stores |
| sign_ext | input | 1 | Sign-extend narrow loads when high |
| rdata | output | 32 | Load result, one cycle after the access |
| misalign | output | 1 | Current access breaks its alignment rule |

## Verification
The bench reads a known word back one byte at a time and one half-word at a time. A design that mirrors the lane order, or picks the wrong half, returns the bytes in reversed or swapped positions. Narrow stores use write data whose upper bits are deliberately non-zero. A design that does not gate its lane enables, or that copies the wrong slice, would corrupt neighbouring bytes or store that upper data. Rejected stores are followed by a read of the target word, so a design that still writes on a flagged access shows the change. A store to a word that already holds data checks that the same access returns the old contents. Aliased addresses with high bits set must reach the same byte, and a design that decodes too many bits would miss it.

// File: rtl/be_mem_pkg.sv
// Shared types for the big-endian data memory.
// Assumes a 32-bit word made of four byte lanes.
package be_mem_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
endpackage

// File: rtl/be_store_steer.sv
// Alignment check and write-lane steering.
// Lane i covers bits [8i+7:8i]. Byte offset k maps to lane 3-k (big-endian).
// Purely combinational; the caller gates nothing further.
module be_store_steer
    import be_mem_pkg::*;
(
    input  logic [1:0]  offset,
    input  acc_size_e   size,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic        misalign,
    output logic [3:0]  lane_we,
    output logic [31:0] lane_wd
);
    logic [3:0] lane_sel;

    // Decide legality, the touched lanes and the replicated store data.
    always_comb begin
        case (size)
            SZ_BYTE: begin
                misalign = 1'b0;
                lane_sel = 4'b1000 >> offset;
                lane_wd  = {4{wdata[7:0]}};
            end
            SZ_HALF: begin
                misalign = offset[0];
                lane_sel = offset[1] ? 4'b0011 : 4'b1100;
                lane_wd  = {2{wdata[15:0]}};
            end
            SZ_WORD: begin
                misalign = |offset;
                lane_sel = 4'b1111;
                lane_wd  = wdata;
            end
            default: begin
                misalign = 1'b1;
                lane_sel = 4'b0000;
                lane_wd  = wdata;
            end
        endcase
    end

    // Only a legal store enables lanes.
    assign lane_we = (wr_en && !misalign) ? lane_sel : 4'b0000;
endmodule

// File: rtl/be_lane_ram.sv
// Byte-lane storage: one 8-bit array per lane, each with its own write enable.
// Reads are registered and return the contents from before a same-edge write.
// Contents are not reset.
module be_lane_ram #(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       lane_we,
    input  logic [31:0]      lane_wd,
    output logic [31:0]      rd_word
);
    genvar g;
    generate
        for (g = 0; g < be_mem_pkg::LANES; g++) begin : g_lane
            logic [7:0] mem [DEPTH];
            logic [7:0] lane_q;

            // Write one lane and capture its old contents for the read path.
            always_ff @(posedge clk) begin
                if (lane_we[g]) mem[idx] <= lane_wd[8*g +: 8];
                lane_q <= mem[idx];
            end

            assign rd_word[8*g +: 8] = lane_q;
        end
    endgenerate
endmodule

// File: rtl/be_load_align.sv
// Load alignment: registers the access controls alongside the RAM read.
// Selects the byte or half-word and right-justifies it with sign or zero fill.
// A rejected access, or the state after reset, yields zero.
module be_load_align
    import be_mem_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  offset,
    input  acc_size_e   size,
    input  logic        sign_ext,
    input  logic        bad,
    input  logic [31:0] word_in,
    output logic [31:0] rdata
);
    logic [1:0] off_q;
    acc_size_e  sz_q;
    logic       sgn_q;
    logic       bad_q;
    logic [7:0]  pick8;
    logic [15:0] pick16;

    // Hold the access controls so they line up with the registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= 2'b00;
            sz_q  <= SZ_WORD;
            sgn_q <= 1'b0;
            bad_q <= 1'b1;
        end else begin
            off_q <= offset;
            sz_q  <= size;
            sgn_q <= sign_ext;
            bad_q <= bad;
        end
    end

    // Choose the addressed byte; offset 0 is the most significant byte.
    always_comb begin
        case (off_q)
            2'd0:    pick8 = word_in[31:24];
            2'd1:    pick8 = word_in[23:16];
            2'd2:    pick8 = word_in[15:8];
            default: pick8 = word_in[7:0];
        endcase
        pick16 = off_q[1] ? word_in[15:0] : word_in[31:16];
    end

    // Extend the chosen field, or force zero on a rejected access.
    always_comb begin
        if (bad_q) begin
            rdata = 32'h0;
        end else begin
            case (sz_q)
                SZ_BYTE: rdata = {{24{sgn_q & pick8[7]}}, pick8};
                SZ_HALF: rdata = {{16{sgn_q & pick16[15]}}, pick16};
                default: rdata = word_in;
            endcase
        end
    end

    // R5
    sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_q && sz_q == SZ_BYTE && sgn_q) |-> (rdata[31:8] == {24{rdata[7]}}));

    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_q && sz_q != SZ_WORD && !sgn_q) |-> (rdata[31:16] == 16'h0));
endmodule

// File: rtl/be_data_mem.sv
// Big-endian byte-addressed data memory, single synchronous port.
// Assumes DEPTH is a power of two no larger than 2^30 words.
// Upper address bits are not decoded; the array repeats across the address space.
module be_data_mem
    import be_mem_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        sign_ext,
    output logic [31:0] rdata,
    output logic        misalign
);
    localparam int IDX_W = $clog2(DEPTH);

    acc_size_e        size_e;
    logic [IDX_W-1:0] idx;
    logic [3:0]       lane_we;
    logic [31:0]      lane_wd;
    logic [31:0]      rd_word;
    logic             unused_hi;

    assign size_e    = acc_size_e'(size);
    assign idx       = addr[IDX_W+1:2];
    assign unused_hi = ^addr[31:IDX_W+2];

    be_store_steer u_steer (
        .offset   (addr[1:0]),
        .size     (size_e),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .misalign (misalign),
        .lane_we  (lane_we),
        .lane_wd  (lane_wd)
    );

    be_lane_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .idx     (idx),
        .lane_we (lane_we),
        .lane_wd (lane_wd),
        .rd_word (rd_word)
    );

    be_load_align u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .offset   (addr[1:0]),
        .size     (size_e),
        .sign_ext (sign_ext),
        .bad      (misalign),
        .word_in  (rd_word),
        .rdata    (rdata)
    );

    // R2
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b10 && addr[1:0] != 2'b00) |-> misalign);

    // R3
    no_bad_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (lane_we == 4'b0000));

    // R4
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && size == 2'b00) |-> ($countones(lane_we) == 1));

    // R7
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> (rdata == 32'h0));
endmodule

// File: tb/test_be_data_mem.sv
// Directed bench for be_data_mem: one task per scenario, each checks its own results.
module test_be_data_mem;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = 32'h0;
    logic [1:0]  size = 2'b10;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic        sign_ext = 1'b0;
    logic [31:0] rdata;
    logic        misalign;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rd;
    logic        mis;

    localparam logic [1:0] B = 2'b00, H = 2'b01, W = 2'b10, X = 2'b11;

    be_data_mem #(.DEPTH(256)) i_be_data_mem (
        .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .wr_en(wr_en),
        .wdata(wdata), .sign_ext(sign_ext), .rdata(rdata), .misalign(misalign)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at a falling edge, flag sampled 1 ns later, data one cycle on.
    task automatic acc(input logic [31:0] a, input logic [1:0] s, input logic we,
                       input logic [31:0] wd, input logic sg);
        addr = a; size = s; wr_en = we; wdata = wd; sign_ext = sg;
        #1 mis = misalign;
        @(negedge clk);
        rd = rdata;
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R9 reset rdata", rdata, 32'h0);
    endtask

    task automatic t_word;
        acc(32'h40, W, 1'b1, 32'h11223344, 1'b0);
        acc(32'h40, W, 1'b0, 32'h0, 1'b0);
        chk("R1 word readback", rd, 32'h11223344);
        chk("R2 aligned word flag", {31'b0, mis}, 32'h0);
    endtask

    task automatic t_byte_order;
        logic [31:0] exp [4] = '{32'h11, 32'h22, 32'h33, 32'h44};
        for (int k = 0; k < 4; k++) begin
            acc(32'h40 + k, B, 1'b0, 32'h0, 1'b0);
            chk("R1 byte lane order", rd, exp[k]);
        end
    endtask

    task automatic t_extend;
        acc(32'h80, W, 1'b1, 32'hA1B2C3D4, 1'b0);
        acc(32'h80, H, 1'b0, 32'h0, 1'b1);
        chk("R5 signed half off0", rd, 32'hFFFFA1B2);
        acc(32'h82, H, 1'b0, 32'h0, 1'b0);
        chk("R5 zero half off2", rd, 32'h0000C3D4);
        acc(32'h81, B, 1'b0, 32'h0, 1'b1);
        chk("R5 signed byte", rd, 32'hFFFFFFB2);
        acc(32'h83, B, 1'b0, 32'h0, 1'b0);
        chk("R5 zero byte", rd, 32'h000000D4);
        acc(32'h82, H, 1'b0, 32'h0, 1'b1);
        chk("R5 signed half negative", rd, 32'hFFFFC3D4);
    endtask

    task automatic t_narrow_store;
        acc(32'hC0, W, 1'b1, 32'h01020304, 1'b0);
        acc(32'hC2, B, 1'b1, 32'h123456EE, 1'b0);
        acc(32'hC0, W, 1'b0, 32'h0, 1'b0);
        chk("R4 byte store lane", rd, 32'h0102EE04);
        acc(32'hC0, H, 1'b1, 32'h7777BEEF, 1'b0);
        acc(32'hC0, W, 1'b0, 32'h0, 1'b0);
        chk("R4 half store off0", rd, 32'hBEEFEE04);
        acc(32'hC2, H, 1'b1, 32'h99991357, 1'b0);
        acc(32'hC0, W, 1'b0, 32'h0, 1'b0);
        chk("R4 half store off2", rd, 32'hBEEF1357);
    endtask

    task automatic t_misaligned;
        acc(32'hC1, W, 1'b1, 32'hDEADDEAD, 1'b0);
        chk("R2 word off1 flagged", {31'b0, mis}, 32'h1);
        chk("R7 rejected rdata zero", rd, 32'h0);
        acc(32'hC3, H, 1'b1, 32'hDEADDEAD, 1'b0);
        chk("R2 half odd flagged", {31'b0, mis}, 32'h1);
        acc(32'hC0, X, 1'b1, 32'hDEADDEAD, 1'b0);
        chk("R2 size code 3 flagged", {31'b0, mis}, 32'h1);
        acc(32'hC0, W, 1'b0, 32'h0, 1'b0);
        chk("R3 memory unchanged", rd, 32'hBEEF1357);
        acc(32'hC3, B, 1'b0, 32'h0, 1'b0);
        chk("R2 byte odd not flagged", {31'b0, mis}, 32'h0);
        chk("R1 byte at +3", rd, 32'h57);
        acc(32'hC1, H, 1'b0, 32'h0, 1'b0);
        chk("R7 rejected load zero", rd, 32'h0);
    endtask

    task automatic t_read_before_write;
        acc(32'h40, W, 1'b1, 32'hCAFEF00D, 1'b0);
        chk("R6 old data on write", rd, 32'h11223344);
        acc(32'h40, W, 1'b0, 32'h0, 1'b0);
        chk("R6 new data next", rd, 32'hCAFEF00D);
    endtask

    task automatic t_alias;
        acc(32'h444, W, 1'b1, 32'h5A5AA5A5, 1'b0);
        acc(32'h44, W, 1'b0, 32'h0, 1'b0);
        chk("R8 alias low", rd, 32'h5A5AA5A5);
        acc(32'h80000045, B, 1'b0, 32'h0, 1'b0);
        chk("R8 alias high bit", rd, 32'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word();
        t_byte_order();
        t_extend();
        t_narrow_store();
        t_misaligned();
        t_read_before_write();
        t_alias();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule